// File: doc/BRIEF.md
# Frame-Tick Timer and Watchdog

This block keeps two counters that run on an 8 kHz frame-sync pulse rather than on the system clock. The first is a general timer. It advances once per frame pulse and emits a one-cycle interrupt pulse each time it reaches its selected terminal count. It then reloads to zero and keeps running. The second is a watchdog. It advances once every 16 frame pulses, which is a 2 ms tick. When it reaches its own terminal count it sets a sticky timeout flag.

Each counter has a 4-bit selector. Selector value n sets the terminal count to 2^(n+1) ticks, so the range runs from 2 to 65536 ticks. Software keeps the watchdog alive in one of two ways:
- pulsing a restart strobe;
- turning on automatic restart, after which every host register access, reported on a strobe input, also restarts it.

The watchdog has two named states:
- `WD_COUNT`: counting. It moves to `WD_EXPIRED` when the count reaches its terminal value on a 2 ms tick.
- `WD_EXPIRED`: timed out, with counting stopped. It returns to `WD_COUNT` on any restart.

A restart in `WD_COUNT` stays in `WD_COUNT` and clears both the 2 ms prescaler and the watchdog count.

Top module: `frame_timer_wdog`

## Requirements
- R1: After reset, `tmr_irq` and `wd_timeout` are 0.
- R2: With `tmr_sel`=n, `tmr_irq` is high for exactly one clock cycle after every 2^(n+1)-th frame pulse counted since reset. The timer reloads to zero and keeps running.
- R3: Each rising edge of `fsync` advances the counters exactly once, however long `fsync` stays high.
- R4: With `wd_sel`=m, `wd_timeout` rises after the 16·2^(m+1)-th frame pulse since reset or since the last restart.
- R5: `wd_timeout` stays at 1 until a restart or a reset, whatever frame pulses arrive.
- R6: A cycle with `wd_kick`=1 clears `wd_timeout` in the next cycle and restarts the watchdog count and its prescaler from zero.
- R7: A cycle with `host_access`=1 restarts the watchdog exactly like `wd_kick` when `auto_kick_en`=1. When `auto_kick_en`=0 it has no effect.
- R8: If `tmr_sel` is lowered so that the current timer count is at or above the new terminal value minus one, the next frame pulse raises `tmr_irq` and reloads the timer to zero.
- R9: A restart that arrives in the same cycle as the frame pulse that would expire the watchdog wins, so `wd_timeout` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse, 8 kHz, synchronous to clk |
| tmr_sel | input | 4 | Timer terminal selector, 2^(n+1) frames |
| wd_sel | input | 4 | Watchdog terminal selector, 2^(n+1) ticks of 2 ms |
| wd_kick | input | 1 | Watchdog restart strobe (write-1) |
| auto_kick_en | input | 1 | Allow host accesses to restart the watchdog |
| host_access | input | 1 | One-cycle strobe per host register access |
| tmr_irq | output | 1 | One-cycle timer expiry pulse |
| wd_timeout | output | 1 | Sticky watchdog timeout flag |

## Verification
The hardest case to reach is a restart landing in the exact clock cycle of the frame edge that would otherwise expire the watchdog. The stimulus drives 31 pulses at the smallest watchdog setting. It then raises `fsync` and `wd_kick` on the same clock edge and checks that no timeout appears. A second awkward case is a timer count that already lies past a newly lowered terminal value. The bench lets the count run to 10 at a large setting, drops the selector, and expects an immediate expiry followed by a normal period.

// File: rtl/frame_tw_pkg.sv
package frame_tw_pkg;
    localparam int SEL_W   = 4;
    localparam int CNT_W   = 2 ** SEL_W;
    localparam int PRESC   = 16;
    localparam int PRESC_W = $clog2(PRESC);

    typedef enum logic [0:0] {
        WD_COUNT   = 1'b0,
        WD_EXPIRED = 1'b1
    } wd_state_e;

    // Last count value before expiry: 2^(sel+1) - 1, built without overflow.
    function automatic logic [CNT_W-1:0] limit_of(input logic [SEL_W-1:0] sel);
        logic [CNT_W-1:0] ones;
        ones = '1;
        return ones >> (CNT_W - 1 - int'(sel));
    endfunction
endpackage

// File: rtl/fs_edge.sv
module fs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic rise
);
    logic fs_q;

    always_ff @(posedge clk) begin
        if (!rst_n) fs_q <= 1'b0;
        else        fs_q <= fsync;
    end

    assign rise = fsync & ~fs_q;

    // R3: a held-high pulse never yields two rises in a row
    assert_single_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/sel_counter.sv
module sel_counter
    import frame_tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim = limit_of(sel);
    assign hit = tick & ~clr & (cnt >= lim);

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= hit ? '0 : cnt + 1'b1;
    end

    // R8: a count at or past the limit must expire on the next tick
    assert_late_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && cnt >= lim) |=> (cnt == '0));
endmodule

// File: rtl/wd_fsm.sv
module wd_fsm
    import frame_tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             timeout
);
    wd_state_e        state, state_nx;
    logic [PRESC_W-1:0] presc;
    logic             wd_tick;
    logic             wd_hit;

    assign wd_tick = rise & ~restart & (state == WD_COUNT) &
                     (presc == PRESC_W'(PRESC - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)                          presc <= '0;
        else if (restart)                    presc <= '0;
        else if (rise && state == WD_COUNT)  presc <= (presc == PRESC_W'(PRESC - 1)) ? '0 : presc + 1'b1;
    end

    sel_counter u_wd_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (wd_tick),
        .clr   (restart),
        .sel   (sel),
        .hit   (wd_hit)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            WD_COUNT:   if (restart) state_nx = WD_COUNT;
                        else if (wd_hit) state_nx = WD_EXPIRED;
            WD_EXPIRED: if (restart) state_nx = WD_COUNT;
            default:    state_nx = WD_COUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_COUNT;
        else        state <= state_nx;
    end

    always_comb begin
        timeout = (state == WD_EXPIRED);
    end

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !restart) |=> timeout);
    assert_restart_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !timeout);
    assert_restart_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && rise && !timeout) |=> !timeout);
endmodule

// File: rtl/frame_timer_wdog.sv
module frame_timer_wdog
    import frame_tw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic [SEL_W-1:0] tmr_sel,
    input  logic [SEL_W-1:0] wd_sel,
    input  logic             wd_kick,
    input  logic             auto_kick_en,
    input  logic             host_access,
    output logic             tmr_irq,
    output logic             wd_timeout
);
    logic fs_rise;
    logic tmr_hit;
    logic restart;

    assign restart = wd_kick | (auto_kick_en & host_access);

    fs_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .rise  (fs_rise)
    );

    sel_counter u_tmr_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (fs_rise),
        .clr   (1'b0),
        .sel   (tmr_sel),
        .hit   (tmr_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_irq <= 1'b0;
        else        tmr_irq <= tmr_hit;
    end

    wd_fsm u_wd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise    (fs_rise),
        .restart (restart),
        .sel     (wd_sel),
        .timeout (wd_timeout)
    );

    assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_irq |=> !tmr_irq);
    assert_irq_from_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_irq) |-> $past(fs_rise));
    assert_timeout_from_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_timeout) |-> $past(fs_rise));
    assert_no_kick_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_timeout && !wd_kick && !auto_kick_en) |=> wd_timeout);
endmodule

// File: tb/sim_frame_timer_wdog.sv
module sim_frame_timer_wdog;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       fsync, wd_kick, auto_kick_en, host_access;
    logic [3:0] tmr_sel, wd_sel;
    logic       tmr_irq, wd_timeout;

    int checks = 0;
    int errors = 0;
    logic irq_s, to_s;

    always #5 clk = ~clk;

    frame_timer_wdog u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .tmr_sel(tmr_sel), .wd_sel(wd_sel),
        .wd_kick(wd_kick), .auto_kick_en(auto_kick_en), .host_access(host_access),
        .tmr_irq(tmr_irq), .wd_timeout(wd_timeout)
    );

    // {tmr_sel, wd_sel}
    localparam logic [7:0] VEC [6] = '{8'h00, 8'h10, 8'h21, 8'h30, 8'h41, 8'h52};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; fsync = 1'b0; wd_kick = 1'b0; host_access = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One frame pulse; outputs sampled the cycle after the edge that counts it.
    task automatic frame(input logic kick);
        @(negedge clk);
        fsync = 1'b1; wd_kick = kick;
        @(negedge clk);
        irq_s = tmr_irq; to_s = wd_timeout;
        fsync = 1'b0; wd_kick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_kick(input logic via_host);
        @(negedge clk);
        if (via_host) host_access = 1'b1; else wd_kick = 1'b1;
        @(negedge clk);
        host_access = 1'b0; wd_kick = 1'b0;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; fsync = 1'b0; wd_kick = 1'b0; auto_kick_en = 1'b0;
        host_access = 1'b0; tmr_sel = '0; wd_sel = '0;
        do_reset();
        check("R1 irq", int'(tmr_irq), 0);
        check("R1 timeout", int'(wd_timeout), 0);

        // Table walk: R2 irq count, R4 first timeout frame
        for (int v = 0; v < 6; v++) begin
            int tp, wp, nf, nirq, first_to;
            tmr_sel = VEC[v][7:4];
            wd_sel  = VEC[v][3:0];
            tp = 1 << (int'(tmr_sel) + 1);
            wp = 16 * (1 << (int'(wd_sel) + 1));
            nf = wp + 2;
            nirq = 0; first_to = 0;
            do_reset();
            for (int f = 1; f <= nf; f++) begin
                frame(1'b0);
                if (irq_s) nirq++;
                if (to_s && first_to == 0) first_to = f;
            end
            check("R2 irq count", nirq, nf / tp);
            check("R4 timeout frame", first_to, wp);
        end

        // R2: pulse lasts one cycle
        tmr_sel = 4'd0; wd_sel = 4'd3;
        do_reset();
        frame(1'b0);
        frame(1'b0);
        check("R2 irq high", int'(irq_s), 1);
        check("R2 irq one cycle", int'(tmr_irq), 0);

        // R3: long-high fsync counts once
        do_reset();
        @(negedge clk); fsync = 1'b1;
        repeat (10) @(negedge clk);
        check("R3 no irq during long high", int'(tmr_irq), 0);
        fsync = 1'b0;
        @(negedge clk);
        frame(1'b0);
        check("R3 second edge expires", int'(irq_s), 1);

        // R8: lower selector below current count
        tmr_sel = 4'd3;
        do_reset();
        for (int f = 0; f < 10; f++) frame(1'b0);
        tmr_sel = 4'd1;
        frame(1'b0);
        check("R8 immediate expiry", int'(irq_s), 1);
        for (int f = 0; f < 3; f++) frame(1'b0);
        check("R8 no irq before period", int'(irq_s), 0);
        frame(1'b0);
        check("R8 period after reload", int'(irq_s), 1);

        // R6: kick mid-count restarts
        tmr_sel = 4'd0; wd_sel = 4'd0; auto_kick_en = 1'b0;
        do_reset();
        for (int f = 0; f < 20; f++) frame(1'b0);
        pulse_kick(1'b0);
        for (int f = 0; f < 31; f++) frame(1'b0);
        check("R6 restarted count not expired", int'(to_s), 0);
        frame(1'b0);
        check("R6 expires 32 after kick", int'(to_s), 1);

        // R5 and R7 ignored: sticky through frames and host access with auto off
        for (int f = 0; f < 5; f++) frame(1'b0);
        pulse_kick(1'b1);
        @(negedge clk);
        check("R5 R7 sticky, host access ignored", int'(wd_timeout), 1);

        // R6: kick clears flag
        pulse_kick(1'b0);
        check("R6 kick clears", int'(wd_timeout), 0);

        // R7: auto restart via host access
        for (int f = 0; f < 32; f++) frame(1'b0);
        check("R7 setup expired", int'(wd_timeout), 1);
        auto_kick_en = 1'b1;
        pulse_kick(1'b1);
        check("R7 host access clears", int'(wd_timeout), 0);
        auto_kick_en = 1'b0;

        // R9: kick on the expiring frame wins
        do_reset();
        for (int f = 0; f < 31; f++) frame(1'b0);
        frame(1'b1);
        check("R9 kick wins over expiry", int'(to_s), 0);
        for (int f = 0; f < 32; f++) frame(1'b0);
        check("R9 full period after", int'(to_s), 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule